// File: doc/BRIEF.md
# Challenge-Response Windowed Watchdog

This block supervises a processor by making it prove, each round, that it is running the right code at the right rate. It presents an 8-bit pseudo-random challenge. The processor must read it, compute an answer, and write that answer back through a simple strobe-and-data register port. This port stands in for a serial slave. A toggling pin or a constant value cannot keep the watchdog satisfied, because the expected answer changes every round.

The answer must be correct, and it must arrive inside a timing window measured from the moment the challenge was issued. If it comes too early, the watchdog treats this as runaway execution. If it comes too late or not at all, this means a stall. A wrong value points to a faulty computation. Repeating the previously accepted answer against a new challenge marks a stuck link.

Any violation raises a reset request and latches a cause code that identifies the case. Both stay asserted until the block itself is reset. Stretching the reset pulse and the physical serial layer belong to neighbouring logic.

Top module: `qa_wdog`

## Requirements
- R1: After reset `chal_o` equals the parameter `SEED` (non-zero), `cause_o` is 0 and `rst_req_o` is 0; `chal_o` is never zero.
- R2: The challenge changes only on an accepted answer. It then takes the value `{c[6:0], c[7]^c[5]^c[4]^c[3]}` one cycle later, where `c` is the old challenge. Otherwise it holds.
- R3: The only correct answer is the CRC-8 of `chal_o ^ KEY`. The CRC is computed MSB first with polynomial 0x07, initial value 0x00, no reflection and no final XOR.
- R4: The round count is 0 in the first cycle a challenge is presented and rises by one per clock. A write (`ans_wr_i` high at a rising edge) with count in [`OPEN_CYC`, `CLOSE_CYC`] is accepted when it is correct and not stuck. Acceptance restarts the count at 0.
- R5: A write with count below `OPEN_CYC` sets cause 1 (early).
- R6: If no write occurs at count `CLOSE_CYC`, cause 2 (late or missing) is set at that edge.
- R7: An in-window write that is incorrect and not stuck sets cause 3 (wrong value).
- R8: An in-window write equal to the last accepted answer sets cause 4 (stuck value). This needs at least one earlier accepted answer, and it takes precedence over cause 3.
- R9: Once non-zero, `cause_o` holds until reset, and `rst_req_o` is high exactly while `cause_o` is non-zero. Later writes are ignored, and `chal_o` is frozen.
- R10: Early detection takes precedence over stuck and wrong checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chal_o | output | 8 | Current challenge byte |
| ans_wr_i | input | 1 | Answer write strobe |
| ans_i | input | 8 | Answer byte, sampled with the strobe |
| rst_req_o | output | 1 | Reset request to the processor |
| cause_o | output | 3 | Latched fault cause: 0 none, 1 early, 2 late, 3 wrong, 4 stuck |

## Verification
Several rounds are answered correctly at the exact window edges and in the middle of the window. This checks that the boundaries are inclusive and that the challenge sequence advances only on acceptance. Single faults are then injected: a write one cycle before the window opens, silence past the timeout, a corrupted answer, and a replay of the previous answer. Each of these must yield its own cause code. A replayed value written before the window opens separates the early-over-stuck precedence from the stuck check itself. Writes sent after a fault show that the latched state and the frozen challenge ignore them.

// File: rtl/qa_wdog_pkg.sv
`timescale 1ns/1ps
package qa_wdog_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_EARLY = 3'd1,
    CAUSE_LATE  = 3'd2,
    CAUSE_WRONG = 3'd3,
    CAUSE_STUCK = 3'd4
  } cause_e;

  function automatic logic [BYTE_W-1:0] crc8_byte(input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] c;
    c = d;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] lfsr_step(input logic [BYTE_W-1:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/qa_chal_gen.sv
`timescale 1ns/1ps
module qa_chal_gen
  import qa_wdog_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SEED = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [BYTE_W-1:0] chal_o
);
  logic [BYTE_W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= SEED;
    else if (adv_i) st_q <= lfsr_step(st_q);
  end

  assign chal_o = st_q;
endmodule

// File: rtl/qa_win_timer.sv
`timescale 1ns/1ps
module qa_win_timer #(
  parameter int unsigned OPEN_CYC  = 8,
  parameter int unsigned CLOSE_CYC = 20,
  localparam int unsigned CNT_W    = $clog2(CLOSE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             early_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] OPEN_C  = CNT_W'(OPEN_CYC);
  localparam logic [CNT_W-1:0] CLOSE_C = CNT_W'(CLOSE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (hold_i)           cnt_q <= cnt_q;
    else if (cnt_q != CLOSE_C) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign early_o   = cnt_q < OPEN_C;
  assign expired_o = cnt_q == CLOSE_C;
endmodule

// File: rtl/qa_ans_judge.sv
`timescale 1ns/1ps
module qa_ans_judge
  import qa_wdog_pkg::*;
#(
  parameter logic [BYTE_W-1:0] KEY = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] chal_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] ans_i,
  input  logic              early_i,
  input  logic              expired_i,
  output logic              accept_o,
  output cause_e            cause_o
);
  cause_e            cause_q, cause_d;
  logic [BYTE_W-1:0] prev_q;
  logic              prev_vld_q;
  logic [BYTE_W-1:0] expect_ans;
  logic              live, stuck, wrong;

  assign expect_ans = crc8_byte(chal_i ^ KEY);
  assign live       = cause_q == CAUSE_NONE;
  assign stuck      = prev_vld_q && (ans_i == prev_q);
  assign wrong      = ans_i != expect_ans;
  assign accept_o   = live && wr_i && !early_i && !stuck && !wrong;

  always_comb begin
    cause_d = cause_q;
    if (live) begin
      if (wr_i) begin
        if (early_i)    cause_d = CAUSE_EARLY;
        else if (stuck) cause_d = CAUSE_STUCK;
        else if (wrong) cause_d = CAUSE_WRONG;
      end else if (expired_i) begin
        cause_d = CAUSE_LATE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q    <= CAUSE_NONE;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      cause_q <= cause_d;
      if (accept_o) begin
        prev_q     <= ans_i;
        prev_vld_q <= 1'b1;
      end
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/qa_wdog.sv
`timescale 1ns/1ps
module qa_wdog
  import qa_wdog_pkg::*;
#(
  parameter int unsigned       OPEN_CYC  = 8,
  parameter int unsigned       CLOSE_CYC = 20,
  parameter logic [BYTE_W-1:0] KEY       = 8'h5A,
  parameter logic [BYTE_W-1:0] SEED      = 8'h01,
  localparam int unsigned      CNT_W     = $clog2(CLOSE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [BYTE_W-1:0] chal_o,
  input  logic              ans_wr_i,
  input  logic [BYTE_W-1:0] ans_i,
  output logic              rst_req_o,
  output logic [2:0]        cause_o
);
  logic [BYTE_W-1:0] chal;
  logic [CNT_W-1:0]  cnt;
  logic              early, expired, accept;
  cause_e            cause;

  qa_chal_gen #(.SEED(SEED)) u_chal (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .chal_o(chal)
  );

  qa_win_timer #(.OPEN_CYC(OPEN_CYC), .CLOSE_CYC(CLOSE_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(accept),
    .hold_i   (cause != CAUSE_NONE),
    .cnt_o    (cnt),
    .early_o  (early),
    .expired_o(expired)
  );

  qa_ans_judge #(.KEY(KEY)) u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .chal_i   (chal),
    .wr_i     (ans_wr_i),
    .ans_i    (ans_i),
    .early_i  (early),
    .expired_i(expired),
    .accept_o (accept),
    .cause_o  (cause)
  );

  assign chal_o    = chal;
  assign cause_o   = cause;
  assign rst_req_o = cause != CAUSE_NONE;
endmodule

// File: rtl/qa_wdog_chk.sv
`timescale 1ns/1ps
module qa_wdog_chk #(
  parameter int unsigned  OPEN_CYC  = 8,
  parameter int unsigned  CLOSE_CYC = 20,
  localparam int unsigned CNT_W     = $clog2(CLOSE_CYC + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       chal_o,
  input logic             ans_wr_i,
  input logic             rst_req_o,
  input logic [2:0]       cause_o,
  input logic [CNT_W-1:0] cnt
);
  a_r9_cause_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != 3'd0) |=> $stable(cause_o));

  a_r9_req_tracks_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o == (cause_o != 3'd0));

  a_r2_chal_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ans_wr_i || cause_o != 3'd0) |=> $stable(chal_o));

  a_r5_early_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ans_wr_i && cause_o == 3'd0 && cnt < CNT_W'(OPEN_CYC)) |=> cause_o == 3'd1);

  a_r6_late_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ans_wr_i && cause_o == 3'd0 && cnt == CNT_W'(CLOSE_CYC)) |=> cause_o == 3'd2);

  always @(negedge clk_i) begin
    if (rst_ni) a_r1_chal_nonzero: assert (chal_o != 8'h00);
  end
endmodule

bind qa_wdog qa_wdog_chk #(.OPEN_CYC(OPEN_CYC), .CLOSE_CYC(CLOSE_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .chal_o   (chal_o),
  .ans_wr_i (ans_wr_i),
  .rst_req_o(rst_req_o),
  .cause_o  (cause_o),
  .cnt      (cnt)
);

// File: tb/qa_wdog_bench.sv
`timescale 1ns/1ps
module qa_wdog_bench;
  localparam int OPEN  = 8;
  localparam int CLOSE = 20;
  localparam logic [7:0] KEY  = 8'h5A;
  localparam logic [7:0] SEED = 8'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [7:0] ans = 8'h00;
  logic [7:0] chal;
  logic req;
  logic [2:0] cause;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  // reference state
  int m_cnt = 0;
  logic [7:0] m_chal = SEED, m_prev = 8'h00;
  bit m_pvld = 0;
  int m_cause = 0;

  always #5 clk = ~clk;

  qa_wdog #(.OPEN_CYC(OPEN), .CLOSE_CYC(CLOSE), .KEY(KEY), .SEED(SEED)) u_qa_wdog (
    .clk_i(clk), .rst_ni(rst_n), .chal_o(chal), .ans_wr_i(wr), .ans_i(ans),
    .rst_req_o(req), .cause_o(cause)
  );

  function automatic logic [7:0] crc(input logic [7:0] d);
    int v = d;
    for (int i = 0; i < 8; i++) begin
      v = v * 2;
      if (v >= 256) v = (v - 256) ^ 7;
    end
    return v[7:0];
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] s);
    logic fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    return {s[6:0], fb};
  endfunction

  task automatic chk(input string t, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", t, got, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_chal = SEED; m_cause = 0; m_pvld = 0; m_prev = 8'h00;
    end else if (m_cause == 0) begin
      if (wr) begin
        if (m_cnt < OPEN) m_cause = 1;
        else if (m_pvld && ans == m_prev) m_cause = 4;
        else if (ans != crc(m_chal ^ KEY)) m_cause = 3;
        else begin
          m_prev = ans; m_pvld = 1; m_chal = nxt(m_chal); m_cnt = 0;
        end
      end else if (m_cnt == CLOSE) m_cause = 2;
      else m_cnt++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({tag, " chal"}, chal, m_chal);
      chk({tag, " cause"}, cause, m_cause);
      chk({tag, " req"}, req, m_cause != 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // mode 0 correct, 1 corrupted, 2 replay of last accepted
  task automatic answer_at(input int k, input int mode);
    logic [7:0] v;
    while (m_cnt != k) @(negedge clk);
    v = crc(m_chal ^ KEY);
    if (mode == 1) begin
      v = v ^ 8'h01;
      if (m_pvld && v == m_prev) v = v ^ 8'h02;
    end else if (mode == 2) v = m_prev;
    wr = 1'b1; ans = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] c0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1 seed", chal, SEED);
    chk("R1 no fault", cause, 0);

    // R4 R2 R3: correct rounds at window edges and inside
    tag = "R4";
    c0 = chal;
    answer_at(OPEN, 0);
    chk("R2 advance", chal, nxt(c0));
    answer_at(CLOSE, 0);
    answer_at(13, 0);
    tag = "R3";
    answer_at(OPEN + 1, 0);
    chk("R3 accepted", cause, 0);
    idle(3);

    // R5 one cycle before opening
    do_reset(); tag = "R5";
    answer_at(OPEN - 1, 0);
    chk("R5 early", cause, 1);
    // R9 later writes ignored, challenge frozen
    tag = "R9";
    c0 = chal;
    wr = 1'b1; ans = crc(chal ^ KEY); idle(3); wr = 1'b0;
    chk("R9 held", cause, 1);
    chk("R9 frozen", chal, c0);
    chk("R9 req", req, 1);

    // R6 silence past timeout
    do_reset(); tag = "R6";
    idle(CLOSE + 4);
    chk("R6 late", cause, 2);

    // R7 wrong answer after one good round
    do_reset(); tag = "R7";
    answer_at(OPEN, 0);
    answer_at(10, 1);
    chk("R7 wrong", cause, 3);

    // R8 replay of previous answer
    do_reset(); tag = "R8";
    answer_at(OPEN, 0);
    answer_at(OPEN + 2, 0);
    answer_at(12, 2);
    chk("R8 stuck", cause, 4);

    // R10 replay before window opens reads as early
    do_reset(); tag = "R10";
    answer_at(OPEN, 0);
    answer_at(2, 2);
    chk("R10 early wins", cause, 1);

    // R7 wrong on very first round (no history, so not stuck)
    do_reset(); tag = "R7";
    answer_at(CLOSE, 1);
    chk("R7 first wrong", cause, 3);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule